// File: doc/BRIEF.md
# Serial-bus control register target for a stereo tone and volume processor

This block is a write-only two-wire serial bus target that holds the eight control settings of a stereo audio processor: source selection, source gain, main volume, three tone bands (bass, middle, treble) and a separate attenuator for each speaker. It samples the bus clock and data lines with its own system clock. It recognises START and STOP conditions and compares the first byte of each transfer with a fixed device address. It pulls the data line low for the acknowledge clock of every byte it accepts.

A transfer that matches the address carries a subaddress byte and then any number of data bytes. The subaddress gives the starting register index and an auto-increment flag. Data bytes are either all stored in the selected register, or stored in consecutive indices. The eight registers drive parallel output ports, so the analog section sees every setting at all times. Reset loads power-on codes that mute the volume and both speakers.

Top module: `tone_ctrl_i2c_target`

## Requirements
- R1: After reset the outputs hold: source select 8'h02, source gain 8'h0E, volume 8'h38 (muted), bass 8'h07, middle 8'h0E, treble 8'h0E, right speaker 8'h78 (muted), left speaker 8'h78 (muted).
- R2: A falling SDA while SCL is high starts a transfer. A rising SDA while SCL is high ends it. Bytes clocked in after a STOP and before the next START are not acknowledged and change no register.
- R3: When the first byte after a START is 8'h88, the block pulls SDA low during the ninth (acknowledge) SCL clock of that byte, and also for each later byte of the transfer. During the eight data clocks of any byte it leaves SDA released.
- R4: Any other first byte (8'h89 included) is not acknowledged, and the rest of that transfer is neither acknowledged nor stored. A repeated START restarts address matching within the same transfer.
- R5: In the subaddress byte, bits 3:0 give the register index and bit 4 is the auto-increment flag. Bits 7:5 have no effect.
- R6: Register indices 0 through 7 drive, in that order, source select, source gain, volume, bass, middle, treble, right speaker and left speaker. Each data byte is stored whole.
- R7: With the auto-increment flag at 0, every data byte of the transfer is written to the selected index, and the last one remains.
- R8: With the auto-increment flag at 1, the first data byte goes to the selected index and each later byte goes to the next index. The 4-bit index wraps from 15 to 0.
- R9: Data bytes aimed at indices 8 through 15 are acknowledged and then discarded, leaving all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| srcSelect | output | 8 | Register 0: source select code |
| srcGain | output | 8 | Register 1: source gain code |
| volumeCode | output | 8 | Register 2: volume code |
| bassCode | output | 8 | Register 3: bass code |
| midCode | output | 8 | Register 4: middle code |
| trebleCode | output | 8 | Register 5: treble code |
| spkRightCode | output | 8 | Register 6: right speaker attenuation |
| spkLeftCode | output | 8 | Register 7: left speaker attenuation |

## Verification
The checks that run on every cycle cover the following: the acknowledge pull-down starts only while the synchronised clock is low, and it is never driven after an address mismatch. A STOP returns the control to idle. The bank stays frozen whenever no write strobe is present or the index points above 7, and the index holds still across writes without auto-increment. Some behaviour can only be seen in the bench's bus scenarios. These are the exact power-on codes, where each index lands on the outputs, the last-byte-wins rule, and the index wrap from 15 to 0. The bench also shows that stray bytes after a STOP are ignored, and that a repeated START after a mismatch recovers the transfer. All of these are observed at the ports against a behavioural register model.

// File: rtl/tone_ctrl_pkg.sv
package tone_ctrl_pkg;

  localparam int REG_W = 8;

  // Strobes from bus control to the register bank, valid for one cycle.
  typedef struct packed {
    logic             setIdx;   // byteVal is a subaddress
    logic             wrData;   // byteVal is a data byte
    logic [REG_W-1:0] byteVal;
  } tciStrobe_t;

  // Power-on codes per register index.
  function automatic logic [REG_W-1:0] powerOnCode(input int idx);
    case (idx)
      0:       return 8'h02;  // second source
      1:       return 8'h0E;  // 28 dB gain
      2:       return 8'h38;  // volume muted
      3:       return 8'h07;  // bass flat
      4:       return 8'h0E;  // middle +2 dB
      5:       return 8'h0E;  // treble +2 dB
      6:       return 8'h78;  // right speaker muted
      7:       return 8'h78;  // left speaker muted
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/tci_bus_ctrl.sv
module tci_bus_ctrl
  import tone_ctrl_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] ADDR_BYTE   = 8'h88
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       ackDrive,
  output tciStrobe_t strobe
);

  localparam int CNT_W = $clog2(REG_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(REG_W);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_SKIP} busState_t;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic startSeen, stopSeen, sclRise, sclFall;
  busState_t st;
  logic [CNT_W-1:0] bitCnt;
  logic inAck;
  logic [REG_W-1:0] shReg;

  // Two-wire lines pass through a synchroniser chain, then one more stage for edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign startSeen = sclS && sclP && sdaP && !sdaS;
  assign stopSeen  = sclS && sclP && !sdaP && sdaS;
  assign sclRise   = sclS && !sclP;
  assign sclFall   = !sclS && sclP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      bitCnt   <= '0;
      inAck    <= 1'b0;
      ackDrive <= 1'b0;
      shReg    <= '0;
      strobe   <= '0;
    end else begin
      strobe.setIdx <= 1'b0;
      strobe.wrData <= 1'b0;
      if (startSeen) begin
        st       <= ST_ADDR;
        bitCnt   <= '0;
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
      end else if (stopSeen) begin
        st       <= ST_IDLE;
        bitCnt   <= '0;
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
      end else if (st == ST_ADDR || st == ST_SUB || st == ST_DATA) begin
        if (sclRise && !inAck && bitCnt != FULL_CNT) begin
          shReg  <= {shReg[REG_W-2:0], sdaS};
          bitCnt <= bitCnt + 1'b1;
        end else if (sclFall && inAck) begin
          inAck    <= 1'b0;
          ackDrive <= 1'b0;
        end else if (sclFall && bitCnt == FULL_CNT) begin
          bitCnt <= '0;
          case (st)
            ST_ADDR: begin
              if (shReg == ADDR_BYTE) begin
                inAck    <= 1'b1;
                ackDrive <= 1'b1;
                st       <= ST_SUB;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_SUB: begin
              inAck          <= 1'b1;
              ackDrive       <= 1'b1;
              strobe.setIdx  <= 1'b1;
              strobe.byteVal <= shReg;
              st             <= ST_DATA;
            end
            default: begin
              inAck          <= 1'b1;
              ackDrive       <= 1'b1;
              strobe.wrData  <= 1'b1;
              strobe.byteVal <= shReg;
            end
          endcase
        end
      end
    end
  end

  // R3
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !sclS);

  // R4
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_SKIP) |-> !ackDrive);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen && !startSeen |=> (st == ST_IDLE) && !ackDrive);

  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setIdx, strobe.wrData}));

endmodule

// File: rtl/tci_reg_bank.sv
module tci_reg_bank
  import tone_ctrl_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tciStrobe_t                strobe,
  output logic [NUM_REGS*REG_W-1:0] bankFlat
);

  logic [IDX_W-1:0] idx;
  logic             autoInc;
  logic [REG_W-1:0] bank [NUM_REGS];

  // Index and flag come from the subaddress; bits above the flag are dropped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx     <= '0;
      autoInc <= 1'b0;
    end else if (strobe.setIdx) begin
      idx     <= strobe.byteVal[IDX_W-1:0];
      autoInc <= strobe.byteVal[IDX_W];
    end else if (strobe.wrData && autoInc) begin
      idx <= idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bank[g] <= powerOnCode(g);
      else if (strobe.wrData && idx == IDX_W'(g))
        bank[g] <= strobe.byteVal;
    end
    assign bankFlat[g*REG_W +: REG_W] = bank[g];
  end

  // R9
  high_idx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData && (idx >= IDX_W'(NUM_REGS)) |=> $stable(bankFlat));

  // R6
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrData |=> $stable(bankFlat));

  // R7
  fixed_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData && !autoInc |=> $stable(idx));

endmodule

// File: rtl/tone_ctrl_i2c_target.sv
module tone_ctrl_i2c_target
  import tone_ctrl_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] ADDR_BYTE   = 8'h88,
  parameter int               NUM_REGS    = 8,
  parameter int               IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  output logic [REG_W-1:0] srcSelect,
  output logic [REG_W-1:0] srcGain,
  output logic [REG_W-1:0] volumeCode,
  output logic [REG_W-1:0] bassCode,
  output logic [REG_W-1:0] midCode,
  output logic [REG_W-1:0] trebleCode,
  output logic [REG_W-1:0] spkRightCode,
  output logic [REG_W-1:0] spkLeftCode
);

  tciStrobe_t                strobe;
  logic [NUM_REGS*REG_W-1:0] bankFlat;

  tci_bus_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_BYTE  (ADDR_BYTE)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .ackDrive(sdaPullLow),
    .strobe  (strobe)
  );

  tci_reg_bank #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) uBank (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bankFlat(bankFlat)
  );

  assign srcSelect    = bankFlat[0*REG_W +: REG_W];
  assign srcGain      = bankFlat[1*REG_W +: REG_W];
  assign volumeCode   = bankFlat[2*REG_W +: REG_W];
  assign bassCode     = bankFlat[3*REG_W +: REG_W];
  assign midCode      = bankFlat[4*REG_W +: REG_W];
  assign trebleCode   = bankFlat[5*REG_W +: REG_W];
  assign spkRightCode = bankFlat[6*REG_W +: REG_W];
  assign spkLeftCode  = bankFlat[7*REG_W +: REG_W];

endmodule

// File: tb/tb_tone_ctrl_i2c_target.sv
`timescale 1ns/1ps
module tb_tone_ctrl_i2c_target;

  localparam int H = 10;  // system clocks per half SCL period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullLow;
  logic [7:0] outs [8];
  wire sdaLine = mSda & ~sdaPullLow;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit settled = 1'b0;
  logic [7:0] model [8];
  logic [7:0] payload [$];

  always #2.5 clk = ~clk;

  tone_ctrl_i2c_target dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .srcSelect(outs[0]), .srcGain(outs[1]), .volumeCode(outs[2]), .bassCode(outs[3]),
    .midCode(outs[4]), .trebleCode(outs[5]), .spkRightCode(outs[6]), .spkLeftCode(outs[7])
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model compared with the outputs on every settled clock (R6).
  always @(negedge clk) begin
    if (settled && !done && rstN) begin
      for (int i = 0; i < 8; i++) begin
        total++;
        if (outs[i] !== model[i]) begin
          bad++;
          if (bad < 12) $display("FAIL R6 reg%0d actual=%h expected=%h at %0t", i, outs[i], model[i], $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic sendStart();
    mSda = 1'b1; tick(H);
    scl = 1'b1;  tick(H);
    mSda = 1'b0; tick(H);
    scl = 1'b0;  tick(H);
  endtask

  task automatic sendStop();
    tick(2); mSda = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendBit(input logic b);
    tick(2); mSda = b; tick(H);
    scl = 1'b1; tick(H/2);
    chk("R3 released during data bit", {7'd0, sdaPullLow}, 8'd0);
    tick(H/2);
    scl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    settled = 1'b0;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    tick(2); mSda = 1'b1; tick(H);
    scl = 1'b1; tick(H/2);
    chk(tag, {7'd0, sdaPullLow}, {7'd0, expAck});
    tick(H/2);
    scl = 1'b0; tick(6);
  endtask

  // Full transfer: START, address, subaddress, payload, optional STOP.
  task automatic xfer(input logic [7:0] addr, input logic [7:0] sub, input bit withStop);
    bit match;
    int idx;
    match = (addr == 8'h88);
    sendStart();
    sendByte(addr, match, match ? "R3 address ack" : "R4 address nack");
    settled = 1'b1;
    sendByte(sub, match, match ? "R5 subaddress ack" : "R4 subaddress ignored");
    settled = 1'b1;
    idx = int'(sub[3:0]);
    foreach (payload[k]) begin
      sendByte(payload[k], match, (idx >= 8) ? "R9 high index ack" : "R8 data ack");
      if (match && idx < 8) model[idx] = payload[k];
      if (match && sub[4]) idx = (idx + 1) % 16;
      settled = 1'b1;
    end
    if (withStop) sendStop();
  endtask

  initial begin
    model[0] = 8'h02; model[1] = 8'h0E; model[2] = 8'h38; model[3] = 8'h07;
    model[4] = 8'h0E; model[5] = 8'h0E; model[6] = 8'h78; model[7] = 8'h78;
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1 power-on codes
    for (int i = 0; i < 8; i++) chk("R1 reset code", outs[i], model[i]);
    chk("R1 no pull at reset", {7'd0, sdaPullLow}, 8'd0);
    settled = 1'b1;

    // R6 single write to volume, no increment
    payload = {8'h05};
    xfer(8'h88, 8'h02, 1'b1);
    chk("R6 volume written", outs[2], 8'h05);

    // R5 bits 7:5 of the subaddress are ignored: 0xE3 selects bass
    payload = {8'h0C};
    xfer(8'h88, 8'hE3, 1'b1);
    chk("R5 bass via E3", outs[3], 8'h0C);

    // R7 no increment: last byte wins on middle
    payload = {8'h11, 8'h22, 8'h33};
    xfer(8'h88, 8'h04, 1'b1);
    chk("R7 last byte kept", outs[4], 8'h33);
    chk("R7 treble untouched", outs[5], 8'h0E);

    // R8 increment across the whole bank
    payload = {8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
    xfer(8'h88, 8'h10, 1'b1);
    for (int i = 0; i < 8; i++) chk("R8 sequential fill", outs[i], 8'hA0 + 8'(i));

    // R9 increment runs past index 7 into dropped indices
    payload = {8'h56, 8'h57, 8'h58, 8'h59};
    xfer(8'h88, 8'h16, 1'b1);
    chk("R9 right speaker", outs[6], 8'h56);
    chk("R9 left speaker", outs[7], 8'h57);
    chk("R9 source select kept", outs[0], 8'hA0);

    // R8 wrap from 15 to 0
    payload = {8'hE1, 8'hE2, 8'hE3, 8'hE4};
    xfer(8'h88, 8'h1E, 1'b1);
    chk("R8 wrap to index 0", outs[0], 8'hE3);
    chk("R8 wrap to index 1", outs[1], 8'hE4);

    // R9 fixed high index, acknowledged and dropped
    payload = {8'h99, 8'h98};
    xfer(8'h88, 8'h08, 1'b1);
    chk("R9 dropped, volume kept", outs[2], 8'hA2);

    // R4 wrong address, then repeated START with the right one
    payload = {8'h00};
    xfer(8'h90, 8'h02, 1'b0);
    chk("R4 mismatch ignored", outs[2], 8'hA2);
    payload = {8'h2A};
    xfer(8'h88, 8'h02, 1'b1);
    chk("R4 repeated start accepted", outs[2], 8'h2A);

    // R4 read-direction address is not this target
    payload = {8'h00};
    xfer(8'h89, 8'h03, 1'b1);
    chk("R4 read address ignored", outs[3], 8'hA3);

    // R2 bytes after STOP without a START
    tick(4); scl = 1'b0; tick(H);
    sendByte(8'h88, 1'b0, "R2 stray address");
    settled = 1'b1;
    sendByte(8'h02, 1'b0, "R2 stray subaddress");
    settled = 1'b1;
    sendByte(8'h00, 1'b0, "R2 stray data");
    settled = 1'b1;
    sendStop();
    chk("R2 volume unchanged", outs[2], 8'h2A);

    tick(20);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule